// File: doc/BRIEF.md
# Ticket Lock Arbiter

This block serializes access to one shared lock among several requesters using a pair of counters: a dispenser counter that hands out tickets and a serving counter that names the ticket currently allowed in. A requester that raises its acquire line while idle receives, in a single atomic fetch-and-increment, the current dispenser value as its ticket. The atomic step happens on arrival, whether or not the lock is free. The requester then waits. Its grant line rises one cycle after the serving counter reaches its ticket.

The lock owner ends its tenure by pulsing the shared release line. This advances the serving counter by one, and the next ticket holder in line is granted. Because tickets are issued in arrival order and served in ticket order, access is strictly first come, first served. Requesters that arrive in the same cycle are ordered by their index. Both counters wrap around, so the unit can run indefinitely.

Top module: `ticket_lock_unit`

## Requirements
- R1: After reset both counters read 0, no requester holds a ticket, no grant is raised and the error flag is low.
- R2: An acquire from an idle requester is taken at a clock edge. After that edge the requester holds a ticket equal to the dispenser value before the edge, and the dispenser has advanced by one.
- R3: Acquires from several idle requesters at the same edge receive consecutive tickets, with the lowest requester index getting the lowest ticket. The dispenser advances by the number of acquires taken.
- R4: An acquire from a requester that already holds a ticket is ignored: its ticket and the dispenser are unchanged.
- R5: A requester's grant rises one clock edge after the serving counter first equals its held ticket. With the lock free, this is one edge after the acquire is taken.
- R6: At most one grant is high at any time.
- R7: A release while a grant is high advances the serving counter by one and returns the granted requester to idle, with its grant and held flag low.
- R8: A release while no grant is high leaves the serving counter unchanged and raises the error flag for exactly the following cycle.
- R9: Grants are given in ticket order, so a requester that arrived earlier is granted before one that arrived later, whatever their indices.
- R10: Both counters are 8 bits wide and wrap from 255 to 0. Issuing, matching and granting continue correctly across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acq_i | input | NREQ | Per-requester acquire request |
| rel_i | input | 1 | Release pulse from the current lock owner |
| held_o | output | NREQ | Requester holds a ticket (waiting or granted) |
| ticket_o | output | NREQ*CW | Ticket held by each requester, requester i at bits [i*CW +: CW] |
| grant_o | output | NREQ | Requester owns the lock |
| serving_o | output | CW | Serving counter |
| dispense_o | output | CW | Next ticket to be handed out |
| rel_err_o | output | 1 | One-cycle flag for a release with no owner |

## Verification
A lone acquire on a free lock checks the basic issue and grant latency. Simultaneous acquires from non-adjacent requesters separate index-ordered ticket numbering from arrival-ordered numbering. A late low-index arrival behind an earlier high-index one tells first-come service apart from fixed-priority arbitration. Repeated acquires from a requester that already holds a ticket, stray releases, and a few hundred acquire-release rounds across the counter wrap cover the ignore, error and modulo behaviour.

// File: rtl/tlu_pkg.sv
package tlu_pkg;
  // number of set bits strictly below position idx
  function automatic int unsigned ones_below(input logic [31:0] v, input int unsigned idx);
    int unsigned n;
    n = 0;
    for (int unsigned k = 0; k < 32; k++)
      if (k < idx && v[k]) n++;
    return n;
  endfunction

  function automatic int unsigned ones_all(input logic [31:0] v);
    return ones_below(v, 32);
  endfunction
endpackage

// File: rtl/tlu_dispenser.sv
module tlu_dispenser #(
  parameter int NREQ = 4,
  parameter int CW   = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NREQ-1:0]           take,
  output logic [CW-1:0]             next_q,
  output logic [NREQ-1:0][CW-1:0]   issue
);
  import tlu_pkg::*;

  logic [CW-1:0] taken_cnt;
  assign taken_cnt = CW'(ones_all(32'(take)));

  for (genvar i = 0; i < NREQ; i++) begin : g_issue
    assign issue[i] = next_q + CW'(ones_below(32'(take), i));
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) next_q <= '0;
    else        next_q <= next_q + taken_cnt;

  // R3: dispenser never moves without an accepted acquire
  a_r3_no_silent_move: assert property (@(posedge clk) disable iff (!rst_n)
    (take == '0) |=> $stable(next_q));
endmodule

// File: rtl/tlu_server.sv
module tlu_server #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  output logic [CW-1:0] serving_q
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       serving_q <= '0;
    else if (advance) serving_q <= serving_q + 1'b1;

  a_r8_hold_still: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(serving_q));
endmodule

// File: rtl/tlu_slot.sv
module tlu_slot #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [CW-1:0] ticket_in,
  input  logic [CW-1:0] serving,
  input  logic          done,
  output logic          held_q,
  output logic [CW-1:0] ticket_q,
  output logic          grant_q
);
  logic turn_hit;
  assign turn_hit = held_q && !grant_q && (ticket_q == serving);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      held_q   <= 1'b0;
      ticket_q <= '0;
      grant_q  <= 1'b0;
    end else begin
      if (take) begin
        held_q   <= 1'b1;
        ticket_q <= ticket_in;
      end else if (done && grant_q) begin
        held_q <= 1'b0;
      end
      if (done && grant_q) grant_q <= 1'b0;
      else if (turn_hit)   grant_q <= 1'b1;
    end

  // R5: a grant only ever covers the ticket being served
  a_r5_grant_matches: assert property (@(posedge clk) disable iff (!rst_n)
    grant_q |-> (held_q && ticket_q == serving));
  // R4: a held ticket is not rewritten while waiting
  a_r4_ticket_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !done) |=> $stable(ticket_q));
endmodule

// File: rtl/ticket_lock_unit.sv
module ticket_lock_unit #(
  parameter int NREQ = 4,
  parameter int CW   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NREQ-1:0]      acq_i,
  input  logic                 rel_i,
  output logic [NREQ-1:0]      held_o,
  output logic [NREQ*CW-1:0]   ticket_o,
  output logic [NREQ-1:0]      grant_o,
  output logic [CW-1:0]        serving_o,
  output logic [CW-1:0]        dispense_o,
  output logic                 rel_err_o
);
  logic [NREQ-1:0]         take;
  logic [NREQ-1:0][CW-1:0] issue;
  logic                    owner_present;
  logic                    rel_ok;
  logic                    rel_bad;

  assign take          = acq_i & ~held_o;
  assign owner_present = |grant_o;
  assign rel_ok        = rel_i && owner_present;
  assign rel_bad       = rel_i && !owner_present;

  tlu_dispenser #(.NREQ(NREQ), .CW(CW)) u_disp (
    .clk(clk), .rst_n(rst_n), .take(take), .next_q(dispense_o), .issue(issue)
  );

  tlu_server #(.CW(CW)) u_srv (
    .clk(clk), .rst_n(rst_n), .advance(rel_ok), .serving_q(serving_o)
  );

  for (genvar i = 0; i < NREQ; i++) begin : g_slot
    tlu_slot #(.CW(CW)) u_slot (
      .clk(clk), .rst_n(rst_n), .take(take[i]), .ticket_in(issue[i]),
      .serving(serving_o), .done(rel_ok),
      .held_q(held_o[i]), .ticket_q(ticket_o[i*CW +: CW]), .grant_q(grant_o[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rel_err_o <= 1'b0;
    else        rel_err_o <= rel_bad;

  a_r6_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));
  a_r7_release_steps: assert property (@(posedge clk) disable iff (!rst_n)
    rel_ok |=> (serving_o == $past(serving_o) + 1'b1) && (grant_o == '0));
  a_r8_stray_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rel_bad |=> rel_err_o && $stable(serving_o));
  a_r8_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !rel_bad |=> !rel_err_o);
endmodule

// File: tb/tb_ticket_lock_unit.sv
module tb_ticket_lock_unit;
  localparam int NREQ = 4;
  localparam int CW   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NREQ-1:0]    acq_i = '0;
  logic               rel_i = 1'b0;
  logic [NREQ-1:0]    held_o;
  logic [NREQ*CW-1:0] ticket_o;
  logic [NREQ-1:0]    grant_o;
  logic [CW-1:0]      serving_o;
  logic [CW-1:0]      dispense_o;
  logic               rel_err_o;

  int n_chk = 0;
  int n_bad = 0;
  int exp_next = 0;
  int exp_serv = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ticket_lock_unit #(.NREQ(NREQ), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .acq_i(acq_i), .rel_i(rel_i),
    .held_o(held_o), .ticket_o(ticket_o), .grant_o(grant_o),
    .serving_o(serving_o), .dispense_o(dispense_o), .rel_err_o(rel_err_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int tk(input int i);
    return int'(ticket_o[i*CW +: CW]);
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_release();
    rel_i = 1'b1; step(); rel_i = 1'b0;
    exp_serv = (exp_serv + 1) % 256;
    check("R7 serving", int'(serving_o), exp_serv);
    check("R7 grant cleared", int'(grant_o), 0);
  endtask

  task automatic t_reset();
    check("R1 dispenser", int'(dispense_o), 0);
    check("R1 serving", int'(serving_o), 0);
    check("R1 held", int'(held_o), 0);
    check("R1 grant", int'(grant_o), 0);
    check("R1 err", int'(rel_err_o), 0);
  endtask

  task automatic t_single();
    acq_i = 4'b0001; step(); acq_i = '0;
    check("R2 held", int'(held_o), 1);
    check("R2 ticket", tk(0), exp_next);
    exp_next = (exp_next + 1) % 256;
    check("R2 dispenser", int'(dispense_o), exp_next);
    check("R5 no grant yet", int'(grant_o), 0);
    step();
    check("R5 grant", int'(grant_o), 1);
    do_release();
    check("R7 held cleared", int'(held_o), 0);
  endtask

  task automatic t_simul();
    int base = exp_next;
    acq_i = 4'b1011; step();
    check("R3 ticket r0", tk(0), base);
    check("R3 ticket r1", tk(1), base + 1);
    check("R3 ticket r3", tk(3), base + 2);
    exp_next = base + 3;
    check("R3 dispenser", int'(dispense_o), exp_next);
    acq_i = 4'b0011; step(); acq_i = '0;
    check("R4 ticket r0 kept", tk(0), base);
    check("R4 dispenser kept", int'(dispense_o), exp_next);
    check("R9 first grant r0", int'(grant_o), 4'b0001);
    do_release();
    step();
    check("R9 second grant r1", int'(grant_o), 4'b0010);
    do_release();
    step();
    check("R9 third grant r3", int'(grant_o), 4'b1000);
    check("R6 one grant", $countones(grant_o), 1);
    do_release();
  endtask

  task automatic t_fifo();
    acq_i = 4'b1000; step();
    acq_i = 4'b0001; step(); acq_i = '0;
    check("R9 early r3 granted", int'(grant_o), 4'b1000);
    check("R9 late r0 ticket", tk(0), (tk(3) + 1) % 256);
    exp_next = (exp_next + 2) % 256;
    do_release();
    step();
    check("R9 late r0 granted", int'(grant_o), 4'b0001);
    do_release();
  endtask

  task automatic t_stray();
    rel_i = 1'b1; step(); rel_i = 1'b0;
    check("R8 err raised", int'(rel_err_o), 1);
    check("R8 serving kept", int'(serving_o), exp_serv);
    step();
    check("R8 err one cycle", int'(rel_err_o), 0);
  endtask

  task automatic t_wrap();
    for (int k = 0; k < 260; k++) begin
      acq_i = 4'b0100; step(); acq_i = '0;
      check("R10 ticket", tk(2), exp_next);
      exp_next = (exp_next + 1) % 256;
      check("R10 dispenser", int'(dispense_o), exp_next);
      step();
      check("R10 grant", int'(grant_o), 4'b0100);
      do_release();
    end
  endtask

  initial begin
    repeat (2) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_single();
    t_simul();
    t_fifo();
    t_stray();
    t_wrap();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 0 expected 1 (run completed)");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule